// File: doc/BRIEF.md
# Mirrored Storage Port Mode Controller

This block sits between N user ports and N storage controllers that hold identical copies of the same data. All of them use a packet handshake in which a beat moves when strobe and acknowledge are both high. Start-of-packet and end-of-packet flags frame each packet. Each beat carries command fields (write, read, identify, sector, count) and data. Each response carries write, read, identify, last, failed and data.

Most of the time the block is in the READ state. Each user port is then wired straight to its own controller, so N reads run side by side and the total read rate is N times that of one controller. Writes always win over reads. As soon as any port holds a write at its sink, the READ to DRAIN transition fires: the block stops passing new read or identify commands and waits for every read already admitted to return its final packet, which has last=1. When no read is outstanding, the DRAIN to WRITE transition fires.

In WRITE, a round-robin pick chooses one writing port. Its command and data beats are copied to every controller, and the other ports stay stalled. Once every controller has answered, the block returns one merged response to that port and picks the next writer. When no write is waiting, the WRITE to READ transition restores the one-to-one paths. The write rate is therefore that of the slowest controller, and the visible capacity is that of one controller.

Inside WRITE, a second state machine steps through three stages. The transition from WS_IDLE to WS_DATA picks the owner. The transition from WS_DATA to WS_RESP happens on the owner's last beat. The transition from WS_RESP back to WS_IDLE happens when the merged response is taken.

Top module: `mirror_mode_ctrl`

## Requirements
- R1: After reset the block is in READ, and no strobe is asserted toward any controller or any user port.
- R2: In READ, a command (write=0) from port k reaches only controller k, and the response packets of controller k are returned only to port k, with data, last and read flags unchanged. Read and identify commands are single-beat packets.
- R3: While any port presents a write (strobe=1, write=1), no read or identify command is passed to any controller. A read issued during a write episode is admitted only after the write response has been delivered.
- R4: WRITE is entered only after every admitted read has delivered its final response packet (eop=1, last=1). No read response is cut off.
- R5: In WRITE, at most one port sees acknowledge. Owners are picked round-robin, starting from the port after the previous owner; after reset the search starts at port 0.
- R6: Every beat of the owner's write packet is delivered exactly once to every controller, in order. The owner's acknowledge rises only when all controllers have taken that beat.
- R7: The write response goes to the owner only after every controller has answered. It is one packet with sop=1, eop=1, write=1, last=1, and failed equal to the OR of the controllers' failed bits.
- R8: After the last pending write has been answered and no write is waiting, the block returns to READ and one-to-one reads resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_stb | input | N | User sink strobe, one bit per port |
| us_sop | input | N | User sink start of packet |
| us_eop | input | N | User sink end of packet |
| us_ack | output | N | User sink acknowledge |
| us_wr | input | N | Command is a write |
| us_rd | input | N | Command is a read |
| us_id | input | N | Command is an identify |
| us_sector | input | N*SW | Start sector per port |
| us_count | input | N*CW | Sector count per port |
| us_data | input | N*DW | Write data per port |
| uo_stb | output | N | User source strobe |
| uo_sop | output | N | User source start of packet |
| uo_eop | output | N | User source end of packet |
| uo_ack | input | N | User source acknowledge |
| uo_wr | output | N | Response belongs to a write |
| uo_rd | output | N | Response belongs to a read |
| uo_id | output | N | Response belongs to an identify |
| uo_last | output | N | Last packet of the response |
| uo_fail | output | N | Error flag of the response |
| uo_data | output | N*DW | Read data per port |
| cs_stb | output | N | Controller sink strobe |
| cs_sop | output | N | Controller sink start of packet |
| cs_eop | output | N | Controller sink end of packet |
| cs_ack | input | N | Controller sink acknowledge |
| cs_wr | output | N | Write flag to controller |
| cs_rd | output | N | Read flag to controller |
| cs_id | output | N | Identify flag to controller |
| cs_sector | output | N*SW | Sector to controller |
| cs_count | output | N*CW | Count to controller |
| cs_data | output | N*DW | Data to controller |
| cr_stb | input | N | Controller source strobe |
| cr_sop | input | N | Controller source start of packet |
| cr_eop | input | N | Controller source end of packet |
| cr_ack | output | N | Controller source acknowledge |
| cr_wr | input | N | Controller response write flag |
| cr_rd | input | N | Controller response read flag |
| cr_id | input | N | Controller response identify flag |
| cr_last | input | N | Controller response last flag |
| cr_fail | input | N | Controller response failed flag |
| cr_data | input | N*DW | Controller response data |

## Verification
The assertions check these properties on every cycle:
- no command strobe reaches a controller while a write waits or the block drains;
- WRITE is never occupied with a read outstanding;
- at most one port is acknowledged in WRITE;
- a controller that has taken a beat is not offered it again;
- the block leaves WRITE as soon as writes run out.

Only the bench scenarios can show the rest:
- the data routing of READ;
- that every controller logs the same write bytes in round-robin owner order;
- the OR of the failed bits;
- that reads in progress finish complete before the first write beat;
- that a read blocked by a write is served once the write response is out.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
    typedef enum logic [1:0] {MODE_READ, MODE_DRAIN, MODE_WRITE} mode_t;
    typedef enum logic [1:0] {WS_IDLE, WS_DATA, WS_RESP} wstage_t;
endpackage

// File: rtl/mirror_rr_pick.sv
module mirror_rr_pick #(
    parameter int N  = 2,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] prev,
    output logic [IW-1:0] pick,
    output logic          any
);
    always_comb begin
        pick = prev;
        any  = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(prev) + off) % N;
            if (!any && req[idx]) begin
                pick = IW'(idx);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mirror_read_track.sv
module mirror_read_track #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] start,
    input  logic [N-1:0] finish,
    output logic [N-1:0] busy,
    output logic         any_busy
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (start[k])       busy[k] <= 1'b1;
                else if (finish[k]) busy[k] <= 1'b0;
            end
        end
    end

    assign any_busy = |busy;
endmodule

// File: rtl/mirror_resp_join.sv
module mirror_resp_join #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [N-1:0] take,
    input  logic [N-1:0] fail_in,
    output logic [N-1:0] got,
    output logic         all_got,
    output logic         fail_any
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            got      <= '0;
            fail_any <= 1'b0;
        end else begin
            got      <= got | take;
            fail_any <= fail_any | (|(take & fail_in));
        end
    end

    assign all_got = &got;
endmodule

// File: rtl/mirror_mode_ctrl.sv
module mirror_mode_ctrl
    import mirror_pkg::*;
#(
    parameter int N  = 2,
    parameter int DW = 32,
    parameter int SW = 48,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    us_stb,
    input  logic [N-1:0]    us_sop,
    input  logic [N-1:0]    us_eop,
    output logic [N-1:0]    us_ack,
    input  logic [N-1:0]    us_wr,
    input  logic [N-1:0]    us_rd,
    input  logic [N-1:0]    us_id,
    input  logic [N*SW-1:0] us_sector,
    input  logic [N*CW-1:0] us_count,
    input  logic [N*DW-1:0] us_data,
    output logic [N-1:0]    uo_stb,
    output logic [N-1:0]    uo_sop,
    output logic [N-1:0]    uo_eop,
    input  logic [N-1:0]    uo_ack,
    output logic [N-1:0]    uo_wr,
    output logic [N-1:0]    uo_rd,
    output logic [N-1:0]    uo_id,
    output logic [N-1:0]    uo_last,
    output logic [N-1:0]    uo_fail,
    output logic [N*DW-1:0] uo_data,
    output logic [N-1:0]    cs_stb,
    output logic [N-1:0]    cs_sop,
    output logic [N-1:0]    cs_eop,
    input  logic [N-1:0]    cs_ack,
    output logic [N-1:0]    cs_wr,
    output logic [N-1:0]    cs_rd,
    output logic [N-1:0]    cs_id,
    output logic [N*SW-1:0] cs_sector,
    output logic [N*CW-1:0] cs_count,
    output logic [N*DW-1:0] cs_data,
    input  logic [N-1:0]    cr_stb,
    input  logic [N-1:0]    cr_sop,
    input  logic [N-1:0]    cr_eop,
    output logic [N-1:0]    cr_ack,
    input  logic [N-1:0]    cr_wr,
    input  logic [N-1:0]    cr_rd,
    input  logic [N-1:0]    cr_id,
    input  logic [N-1:0]    cr_last,
    input  logic [N-1:0]    cr_fail,
    input  logic [N*DW-1:0] cr_data
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    mode_t   mode, mode_nx;
    wstage_t ws, ws_nx;
    logic [IW-1:0] own, prev_own, pick;
    logic          pick_any;
    logic [N-1:0]  beat_done;
    logic [N-1:0]  wr_req;
    logic          wr_pend;
    logic          beat_vld, beat_acc, resp_done;
    logic [N-1:0]  rd_start, rd_finish, rd_busy, jn_take, jn_got;
    logic          any_busy, all_got, fail_any;

    assign wr_req   = us_stb & us_wr;
    assign wr_pend  = |wr_req;
    assign beat_vld = (mode == MODE_WRITE) && (ws == WS_DATA) && us_stb[own];
    assign beat_acc = beat_vld && (&(beat_done | cs_ack));
    assign resp_done = (mode == MODE_WRITE) && (ws == WS_RESP) && all_got && uo_ack[own];

    mirror_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req(wr_req), .prev(prev_own), .pick(pick), .any(pick_any)
    );

    always_comb begin
        for (int k = 0; k < N; k++) begin
            rd_start[k]  = (mode == MODE_READ) && us_stb[k] && us_ack[k] && us_sop[k] && !us_wr[k];
            rd_finish[k] = (mode != MODE_WRITE) && cr_stb[k] && cr_ack[k] && cr_eop[k] && cr_last[k];
            jn_take[k]   = (mode == MODE_WRITE) && (ws == WS_RESP) && cr_stb[k] && cr_ack[k] && cr_eop[k];
        end
    end

    mirror_read_track #(.N(N)) u_track (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .finish(rd_finish),
        .busy(rd_busy), .any_busy(any_busy)
    );

    mirror_resp_join #(.N(N)) u_join (
        .clk(clk), .rst_n(rst_n), .clear(resp_done), .take(jn_take), .fail_in(cr_fail),
        .got(jn_got), .all_got(all_got), .fail_any(fail_any)
    );

    // next-state logic for both machines
    always_comb begin
        mode_nx = mode;
        ws_nx   = ws;
        unique case (mode)
            MODE_READ:  if (wr_pend) mode_nx = MODE_DRAIN;
            MODE_DRAIN: if (!any_busy) mode_nx = MODE_WRITE;
            MODE_WRITE: if (ws == WS_IDLE && !wr_pend) mode_nx = MODE_READ;
            default:    mode_nx = MODE_READ;
        endcase
        unique case (ws)
            WS_IDLE: if (mode == MODE_WRITE && pick_any) ws_nx = WS_DATA;
            WS_DATA: if (beat_acc && us_eop[own]) ws_nx = WS_RESP;
            WS_RESP: if (resp_done) ws_nx = WS_IDLE;
            default: ws_nx = WS_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_READ;
            ws        <= WS_IDLE;
            own       <= '0;
            prev_own  <= IW'(N - 1);
            beat_done <= '0;
        end else begin
            mode <= mode_nx;
            ws   <= ws_nx;
            if (ws == WS_IDLE && mode == MODE_WRITE && pick_any) own <= pick;
            if (resp_done) prev_own <= own;
            if (beat_acc) beat_done <= '0;
            else if (beat_vld) beat_done <= beat_done | (cs_stb & cs_ack);
        end
    end

    // outputs
    always_comb begin
        cs_sop = us_sop; cs_eop = us_eop; cs_wr = us_wr; cs_rd = us_rd; cs_id = us_id;
        cs_sector = us_sector; cs_count = us_count; cs_data = us_data;
        uo_sop = cr_sop; uo_eop = cr_eop; uo_wr = cr_wr; uo_rd = cr_rd; uo_id = cr_id;
        uo_last = cr_last; uo_fail = cr_fail; uo_data = cr_data;
        cs_stb = '0; us_ack = '0; uo_stb = '0; cr_ack = '0;
        unique case (mode)
            MODE_READ: begin
                for (int k = 0; k < N; k++) begin
                    cs_stb[k] = us_stb[k] && !us_wr[k] && !wr_pend;
                    us_ack[k] = cs_ack[k] && !us_wr[k] && !wr_pend;
                end
                uo_stb = cr_stb;
                cr_ack = uo_ack;
            end
            MODE_DRAIN: begin
                uo_stb = cr_stb;
                cr_ack = uo_ack;
            end
            MODE_WRITE: begin
                for (int k = 0; k < N; k++) begin
                    cs_stb[k] = beat_vld && !beat_done[k];
                    cs_sop[k] = us_sop[own];
                    cs_eop[k] = us_eop[own];
                    cs_wr[k]  = us_wr[own];
                    cs_rd[k]  = 1'b0;
                    cs_id[k]  = 1'b0;
                    cs_sector[k*SW +: SW] = us_sector[int'(own)*SW +: SW];
                    cs_count[k*CW +: CW]  = us_count[int'(own)*CW +: CW];
                    cs_data[k*DW +: DW]   = us_data[int'(own)*DW +: DW];
                    cr_ack[k] = (ws == WS_RESP) && !jn_got[k];
                end
                us_ack[own]  = beat_acc;
                uo_stb[own]  = (ws == WS_RESP) && all_got;
                uo_sop[own]  = 1'b1;
                uo_eop[own]  = 1'b1;
                uo_wr[own]   = 1'b1;
                uo_rd[own]   = 1'b0;
                uo_id[own]   = 1'b0;
                uo_last[own] = 1'b1;
                uo_fail[own] = fail_any;
                uo_data[int'(own)*DW +: DW] = '0;
            end
            default: ;
        endcase
    end

    // R3
    no_read_under_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_WRITE && wr_pend) |-> cs_stb == '0);
    // R4
    write_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |-> !any_busy);
    // R5
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |-> $onehot0(us_ack));
    // R6
    beat_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE && |(cs_stb & cs_ack) && us_ack == '0)
        |=> (cs_stb & $past(cs_stb & cs_ack)) == '0);
    // R8
    back_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE && ws == WS_IDLE && !wr_pend) |=> mode == MODE_READ);
endmodule

// File: tb/mirror_mode_ctrl_bench.sv
module mirror_mode_ctrl_bench;
    localparam int NP = 3;
    localparam int DW = 16;
    localparam int SW = 48;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NP-1:0] us_stb = '0, us_sop = '0, us_eop = '0, us_wr = '0, us_rd = '0, us_id = '0;
    logic [NP*SW-1:0] us_sector = '0;
    logic [NP*CW-1:0] us_count = '0;
    logic [NP*DW-1:0] us_data = '0;
    logic [NP-1:0] us_ack;
    logic [NP-1:0] uo_stb, uo_sop, uo_eop, uo_wr, uo_rd, uo_id, uo_last, uo_fail;
    logic [NP-1:0] uo_ack = '1;
    logic [NP*DW-1:0] uo_data;
    logic [NP-1:0] cs_stb, cs_sop, cs_eop, cs_wr, cs_rd, cs_id;
    logic [NP-1:0] cs_ack = '0;
    logic [NP*SW-1:0] cs_sector;
    logic [NP*CW-1:0] cs_count;
    logic [NP*DW-1:0] cs_data;
    logic [NP-1:0] cr_stb = '0, cr_sop = '1, cr_eop = '1, cr_wr = '0, cr_rd = '0, cr_id = '0;
    logic [NP-1:0] cr_last = '0, cr_fail = '0, cr_ack;
    logic [NP*DW-1:0] cr_data = '0;

    mirror_mode_ctrl #(.N(NP), .DW(DW), .SW(SW), .CW(CW)) u_mirror_mode_ctrl (
        .clk(clk), .rst_n(rst_n),
        .us_stb(us_stb), .us_sop(us_sop), .us_eop(us_eop), .us_ack(us_ack),
        .us_wr(us_wr), .us_rd(us_rd), .us_id(us_id),
        .us_sector(us_sector), .us_count(us_count), .us_data(us_data),
        .uo_stb(uo_stb), .uo_sop(uo_sop), .uo_eop(uo_eop), .uo_ack(uo_ack),
        .uo_wr(uo_wr), .uo_rd(uo_rd), .uo_id(uo_id), .uo_last(uo_last),
        .uo_fail(uo_fail), .uo_data(uo_data),
        .cs_stb(cs_stb), .cs_sop(cs_sop), .cs_eop(cs_eop), .cs_ack(cs_ack),
        .cs_wr(cs_wr), .cs_rd(cs_rd), .cs_id(cs_id),
        .cs_sector(cs_sector), .cs_count(cs_count), .cs_data(cs_data),
        .cr_stb(cr_stb), .cr_sop(cr_sop), .cr_eop(cr_eop), .cr_ack(cr_ack),
        .cr_wr(cr_wr), .cr_rd(cr_rd), .cr_id(cr_id), .cr_last(cr_last),
        .cr_fail(cr_fail), .cr_data(cr_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // controller models
    logic [DW-1:0] q_data [NP][64];
    bit q_last [NP][64];
    bit q_wr [NP][64];
    bit q_fail [NP][64];
    int qh [NP];
    int qt [NP];
    logic [DW-1:0] wlog [NP][64];
    int wcnt [NP];
    bit fail_inj [NP];

    always begin : ctrl_model
        bit sf [NP];
        bit rf [NP];
        bit swr [NP];
        bit seop [NP];
        logic [DW-1:0] sdat [NP];
        int ssec [NP];
        int scnt [NP];
        @(negedge clk);
        #2;
        for (int k = 0; k < NP; k++) begin
            sf[k]   = cs_stb[k] && cs_ack[k];
            rf[k]   = cr_stb[k] && cr_ack[k];
            swr[k]  = cs_wr[k];
            seop[k] = cs_eop[k];
            sdat[k] = cs_data[k*DW +: DW];
            ssec[k] = int'(cs_sector[k*SW +: 12]);
            scnt[k] = int'(cs_count[k*CW +: CW]);
        end
        @(posedge clk);
        for (int k = 0; k < NP; k++) begin
            if (!rst_n) begin
                qh[k] = 0; qt[k] = 0;
                cs_ack[k] <= 1'b0;
                cr_stb[k] <= 1'b0;
            end else begin
                if (rf[k]) qh[k] = (qh[k] + 1) % 64;
                if (sf[k]) begin
                    if (swr[k]) begin
                        wlog[k][wcnt[k] % 64] = sdat[k];
                        wcnt[k]++;
                        if (seop[k]) begin
                            q_data[k][qt[k]] = '0; q_last[k][qt[k]] = 1'b1;
                            q_wr[k][qt[k]] = 1'b1; q_fail[k][qt[k]] = fail_inj[k];
                            qt[k] = (qt[k] + 1) % 64;
                        end
                    end else begin
                        for (int i = 0; i <= scnt[k]; i++) begin
                            q_data[k][qt[k]] = (i < scnt[k]) ? DW'(k * 4096 + ssec[k] + i) : '0;
                            q_last[k][qt[k]] = (i == scnt[k]);
                            q_wr[k][qt[k]] = 1'b0; q_fail[k][qt[k]] = 1'b0;
                            qt[k] = (qt[k] + 1) % 64;
                        end
                    end
                end
                cs_ack[k] <= ((cyc + k) % 3) != 0;
                cr_stb[k] <= (qh[k] != qt[k]);
                cr_data[k*DW +: DW] <= q_data[k][qh[k]];
                cr_last[k] <= q_last[k][qh[k]];
                cr_wr[k]   <= q_wr[k][qh[k]];
                cr_rd[k]   <= !q_wr[k][qh[k]];
                cr_fail[k] <= q_fail[k][qh[k]];
            end
        end
    end

    // user-side response monitor
    logic [DW-1:0] rx_data [NP][64];
    bit rx_last [NP][64];
    bit rx_wr [NP][64];
    bit rx_fail [NP][64];
    int rx_cyc [NP][64];
    int rx_n [NP];
    int first_wcyc = -1;

    always begin : mon
        @(negedge clk);
        #2;
        for (int p = 0; p < NP; p++) begin
            if (uo_stb[p] && uo_ack[p] && rx_n[p] < 64) begin
                rx_data[p][rx_n[p]] = uo_data[p*DW +: DW];
                rx_last[p][rx_n[p]] = uo_last[p];
                rx_wr[p][rx_n[p]]   = uo_wr[p];
                rx_fail[p][rx_n[p]] = uo_fail[p];
                rx_cyc[p][rx_n[p]]  = cyc;
                rx_n[p]++;
            end
            if (cs_stb[p] && cs_ack[p] && cs_wr[p] && first_wcyc < 0) first_wcyc = cyc;
        end
    end

    task automatic clear_logs();
        for (int p = 0; p < NP; p++) begin
            rx_n[p] = 0; wcnt[p] = 0; fail_inj[p] = 1'b0;
        end
        first_wcyc = -1;
    endtask

    task automatic send(input int p, input bit wr, input int sec, input int cnt,
                        input int nb, input int base);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            us_stb[p] = 1'b1; us_sop[p] = (b == 0); us_eop[p] = (b == nb - 1);
            us_wr[p] = wr; us_rd[p] = !wr; us_id[p] = 1'b0;
            us_sector[p*SW +: SW] = SW'(sec);
            us_count[p*CW +: CW]  = CW'(cnt);
            us_data[p*DW +: DW]   = DW'(base + b);
            forever begin
                #1;
                if (us_ack[p]) begin
                    @(posedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        @(negedge clk);
        us_stb[p] = 1'b0;
    endtask

    task automatic wait_rx(input int p, input int n);
        for (int t = 0; t < 3000 && rx_n[p] < n; t++) @(posedge clk);
    endtask

    task automatic check_read(input int p, input int start, input int sec, input int cnt, input string req);
        chk(rx_n[p] >= start + cnt + 1, req, rx_n[p], start + cnt + 1);
        for (int i = 0; i <= cnt; i++) begin
            int exp_d;
            exp_d = (i < cnt) ? p * 4096 + sec + i : 0;
            chk(int'(rx_data[p][start + i]) == exp_d, req, int'(rx_data[p][start + i]), exp_d);
            chk(rx_last[p][start + i] == (i == cnt), req, int'(rx_last[p][start + i]), int'(i == cnt));
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin : main
        clear_logs();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1: nothing strobed after reset
        chk(uo_stb == '0, "R1 uo_stb", int'(uo_stb), 0);
        chk(cs_stb == '0, "R1 cs_stb", int'(cs_stb), 0);

        // R2: one-to-one reads, sweep of counts on all ports in parallel
        for (int c = 1; c <= 4; c++) begin
            clear_logs();
            fork
                send(0, 1'b0, 16 * 0 + c, c, 1, 0);
                send(1, 1'b0, 16 * 1 + c, c, 1, 0);
                send(2, 1'b0, 16 * 2 + c, c, 1, 0);
            join
            for (int p = 0; p < NP; p++) wait_rx(p, c + 1);
            repeat (3) @(posedge clk);
            for (int p = 0; p < NP; p++) check_read(p, 0, 16 * p + c, c, "R2");
            for (int p = 0; p < NP; p++) chk(wcnt[p] == 0, "R2 no write beats", wcnt[p], 0);
        end

        // R3/R4/R6/R7: write mid-stream of reads on ports 0 and 2
        clear_logs();
        fork
            send(0, 1'b0, 100, 8, 1, 0);
            begin
                send(2, 1'b0, 200, 8, 1, 0);
                repeat (3) @(negedge clk);
                send(2, 1'b0, 300, 1, 1, 0);
            end
            begin
                repeat (3) @(negedge clk);
                send(1, 1'b1, 0, 0, 4, 16'hA0);
            end
        join
        wait_rx(1, 1);
        wait_rx(2, 11);
        repeat (3) @(posedge clk);
        // R4: both long reads complete before any write beat
        check_read(0, 0, 100, 8, "R4 port0");
        check_read(2, 0, 200, 8, "R4 port2");
        chk(rx_cyc[0][8] < first_wcyc, "R4 port0 done before write", rx_cyc[0][8], first_wcyc);
        chk(rx_cyc[2][8] < first_wcyc, "R4 port2 done before write", rx_cyc[2][8], first_wcyc);
        // R6: identical copies on all controllers
        for (int k = 0; k < NP; k++) begin
            chk(wcnt[k] == 4, "R6 beat count", wcnt[k], 4);
            for (int i = 0; i < 4; i++)
                chk(int'(wlog[k][i]) == 16'hA0 + i, "R6 beat data", int'(wlog[k][i]), 16'hA0 + i);
        end
        // R7: merged response
        chk(rx_n[1] == 1, "R7 one response", rx_n[1], 1);
        chk(rx_wr[1][0] && rx_last[1][0], "R7 write last flags", int'(rx_wr[1][0]), 1);
        chk(rx_fail[1][0] == 1'b0, "R7 failed clear", int'(rx_fail[1][0]), 0);
        // R3: read issued during the write episode served after write response
        check_read(2, 9, 300, 1, "R3 late read");
        chk(rx_cyc[2][10] > rx_cyc[1][0], "R3 late read after write", rx_cyc[2][10], rx_cyc[1][0]);

        // R5/R6/R7: two simultaneous writers, fail injected on controller 1
        clear_logs();
        fail_inj[1] = 1'b1;
        fork
            send(0, 1'b1, 0, 0, 2, 16'hB0);
            send(2, 1'b1, 0, 0, 2, 16'hC0);
        join
        wait_rx(0, 1);
        wait_rx(2, 1);
        repeat (3) @(posedge clk);
        for (int k = 0; k < NP; k++) begin
            chk(wcnt[k] == 4, "R6 two-writer beat count", wcnt[k], 4);
            chk(int'(wlog[k][0]) == 16'hC0, "R5 port2 first", int'(wlog[k][0]), 16'hC0);
            chk(int'(wlog[k][1]) == 16'hC1, "R6 order", int'(wlog[k][1]), 16'hC1);
            chk(int'(wlog[k][2]) == 16'hB0, "R5 port0 second", int'(wlog[k][2]), 16'hB0);
            chk(int'(wlog[k][3]) == 16'hB1, "R6 order", int'(wlog[k][3]), 16'hB1);
        end
        chk(rx_cyc[0][0] > rx_cyc[2][0], "R5 response order", rx_cyc[0][0], rx_cyc[2][0]);
        chk(rx_fail[0][0] && rx_fail[2][0], "R7 failed is OR", int'(rx_fail[0][0]), 1);

        // R8: reads resume on all ports
        clear_logs();
        fork
            send(0, 1'b0, 40, 2, 1, 0);
            send(1, 1'b0, 50, 2, 1, 0);
            send(2, 1'b0, 60, 2, 1, 0);
        join
        for (int p = 0; p < NP; p++) wait_rx(p, 3);
        repeat (3) @(posedge clk);
        check_read(0, 0, 40, 2, "R8");
        check_read(1, 0, 50, 2, "R8");
        check_read(2, 0, 60, 2, "R8");

        finish_run();
    end
endmodule